// File: doc/BRIEF.md
# Four-Lane GF(2^m) Inverter

This block returns the multiplicative inverse of field elements in GF(2^m), for a field width m from 2 to 8 and any irreducible polynomial of that degree. It raises each element to the power 2^m − 2 through one fixed chain of combinational multipliers and squarers, laid out as an Itoh-Tsujii addition chain. The chain holds four multipliers and seven squarers. For fields narrower than 8 bits, muxes inside the chain pick the intermediate power that field needs. Every multiplier and squarer reduces its product with one set of reduction rows. Those rows are decoded once from the width and polynomial inputs, and all lanes share them.

A 32-bit input word carries four byte lanes. In packed mode all four lanes are inverted independently. In scalar mode only lane 0 is processed and the other lanes are fed zeros, so their logic stays quiet. The result is registered, which gives a latency of one clock. When no request is presented, the output keeps its last value.

Top module: `gf_inv_simd`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is 0.
- R2: valid_o equals valid_i of the previous clock. data_o takes its new value at the edge where valid_i is 1 and is readable in the following cycle.
- R3: At an edge where valid_i is 0, data_o keeps its value.
- R4: With m = 8, every nonzero lane value a yields a result b for which a·b = 1 in the selected field.
- R5: With m from 2 to 7, every nonzero lane value a below 2^m yields its field inverse.
- R6: A lane value of zero yields zero for every m.
- R7: Lane input bits at positions m and above are ignored, so the lane is treated as its low m bits.
- R8: The field polynomial is x^m plus the sum of x^k for each set poly_i[k] with k < m. The bits of poly_i at positions m and above are ignored.
- R9: A width_i value outside 2..8 (0, 1 or 9 to 15) behaves as m = 8.
- R10: With simd_i = 1, lane k (bits 8k+7:8k) of data_o is the inverse of lane k of data_i. With simd_i = 0, lane 0 is inverted and bits 31:8 of the result are zero.
- R11: One width and polynomial setting applies to all four lanes of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| simd_i | input | 1 | 1: four lanes, 0: lane 0 only |
| width_i | input | 4 | Field width m |
| poly_i | input | 8 | Low-order polynomial coefficients |
| data_i | input | 32 | Four packed byte lanes |
| valid_o | output | 1 | Result registered from a request |
| data_o | output | 32 | Four packed inverses |

## Verification
For each field width from 2 to 8, the bench runs every element of that field through the lanes. It checks each result against a brute-force inverse search and also checks that the product with the input is one. A tap mux that picks the wrong power for a narrow field would produce non-inverses only at that width, and the per-width sweep catches this. A second polynomial for widths 8 and 3 exposes reduction rows that were wired for one fixed polynomial. Junk in the upper bits of the data and of poly_i catches a design that forgets to mask them. Illegal width codes, scalar mode with nonzero upper lanes, and idle cycles with changing inputs catch, in turn, a bad width fallback, lanes that leak, and an output register that updates when it should hold.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;
  localparam int GF_W  = 8;
  localparam int CW    = 2 * GF_W - 1;
  localparam int MW    = $clog2(GF_W + 1);

  typedef enum logic [2:0] {
    TAP_B1, TAP_B2, TAP_B3, TAP_B4, TAP_B5, TAP_B6, TAP_B7
  } tap_e;

  typedef struct packed {
    logic [MW-1:0]                m;
    logic [GF_W-1:0]              mask;
    logic [GF_W-2:0][GF_W-1:0]    rows;  // rows[j] = x^(m+j) mod p
    tap_e                         tap;
  } gf_cfg_t;

  function automatic logic [GF_W-1:0] gf_reduce(input logic [CW-1:0] c, input gf_cfg_t cfg);
    logic [CW-1:0]   hi;
    logic [GF_W-1:0] r;
    hi = c >> cfg.m;
    r  = c[GF_W-1:0] & cfg.mask;
    for (int j = 0; j < GF_W - 1; j++) begin
      if (hi[j]) r = r ^ cfg.rows[j];
    end
    return r;
  endfunction
endpackage

// File: rtl/gf_cfg_dec.sv
module gf_cfg_dec
  import gf_inv_pkg::*;
(
  input  logic [MW-1:0]   width_i,
  input  logic [GF_W-1:0] poly_i,
  output gf_cfg_t         cfg_o
);
  logic [MW-1:0]   m;
  logic [GF_W:0]   full;
  logic [GF_W-1:0] p, row, nxt;

  always_comb begin
    m = (width_i >= MW'(2) && width_i <= MW'(GF_W)) ? width_i : MW'(GF_W);
    full = ((GF_W+1)'(1) << m) - (GF_W+1)'(1);
    p    = poly_i & full[GF_W-1:0];
    row  = p;
    cfg_o.m    = m;
    cfg_o.mask = full[GF_W-1:0];
    for (int j = 0; j < GF_W - 1; j++) begin
      cfg_o.rows[j] = row;
      nxt = (row << 1) & full[GF_W-1:0];
      if (row[m - MW'(1)]) nxt = nxt ^ p;
      row = nxt;
    end
    // final squarer operand: alpha^(2^(m-1)-1)
    unique case (m)
      MW'(2):  cfg_o.tap = TAP_B1;
      MW'(3):  cfg_o.tap = TAP_B2;
      MW'(4):  cfg_o.tap = TAP_B3;
      MW'(5):  cfg_o.tap = TAP_B4;
      MW'(6):  cfg_o.tap = TAP_B5;
      MW'(7):  cfg_o.tap = TAP_B6;
      default: cfg_o.tap = TAP_B7;
    endcase
  end
endmodule

// File: rtl/gf_mul.sv
module gf_mul
  import gf_inv_pkg::*;
(
  input  logic [GF_W-1:0] a_i,
  input  logic [GF_W-1:0] b_i,
  input  gf_cfg_t         cfg_i,
  output logic [GF_W-1:0] p_o
);
  logic [CW-1:0] c;

  always_comb begin
    c = '0;
    for (int i = 0; i < GF_W; i++) begin
      if (b_i[i]) c = c ^ (CW'(a_i) << i);
    end
    p_o = gf_reduce(c, cfg_i);
  end
endmodule

// File: rtl/gf_sqr.sv
module gf_sqr
  import gf_inv_pkg::*;
(
  input  logic [GF_W-1:0] a_i,
  input  gf_cfg_t         cfg_i,
  output logic [GF_W-1:0] s_o
);
  logic [CW-1:0] c;

  always_comb begin
    c = '0;
    for (int i = 0; i < GF_W; i++) c[2*i] = a_i[i];
    s_o = gf_reduce(c, cfg_i);
  end
endmodule

// File: rtl/gf_inv_lane.sv
module gf_inv_lane
  import gf_inv_pkg::*;
(
  input  logic [GF_W-1:0] a_i,
  input  gf_cfg_t         cfg_i,
  output logic [GF_W-1:0] inv_o
);
  // b_k denotes alpha^(2^k - 1)
  logic [GF_W-1:0] a, s1, b2, s2, b3, s3, s4, s5, l3, r3, b456, s6, b7, fin;

  assign a = a_i & cfg_i.mask;

  gf_sqr u_sq1 (.a_i(a),  .cfg_i(cfg_i), .s_o(s1));
  gf_mul u_mu1 (.a_i(s1), .b_i(a), .cfg_i(cfg_i), .p_o(b2));
  gf_sqr u_sq2 (.a_i(b2), .cfg_i(cfg_i), .s_o(s2));
  gf_mul u_mu2 (.a_i(s2), .b_i(a), .cfg_i(cfg_i), .p_o(b3));
  gf_sqr u_sq3 (.a_i(b3), .cfg_i(cfg_i), .s_o(s3));
  gf_sqr u_sq4 (.a_i(s3), .cfg_i(cfg_i), .s_o(s4));
  gf_sqr u_sq5 (.a_i(s4), .cfg_i(cfg_i), .s_o(s5));

  // third multiplier forms b4, b5 or b6 depending on the field
  always_comb begin
    unique case (cfg_i.tap)
      TAP_B4:  begin l3 = s3; r3 = a;  end
      TAP_B5:  begin l3 = s4; r3 = b2; end
      default: begin l3 = s5; r3 = b3; end
    endcase
  end

  gf_mul u_mu3 (.a_i(l3), .b_i(r3), .cfg_i(cfg_i), .p_o(b456));
  gf_sqr u_sq6 (.a_i(b456), .cfg_i(cfg_i), .s_o(s6));
  gf_mul u_mu4 (.a_i(s6), .b_i(a), .cfg_i(cfg_i), .p_o(b7));

  always_comb begin
    unique case (cfg_i.tap)
      TAP_B1:                 fin = a;
      TAP_B2:                 fin = b2;
      TAP_B3:                 fin = b3;
      TAP_B4, TAP_B5, TAP_B6: fin = b456;
      default:                fin = b7;
    endcase
  end

  gf_sqr u_sq7 (.a_i(fin), .cfg_i(cfg_i), .s_o(inv_o));
endmodule

// File: rtl/gf_inv_simd.sv
module gf_inv_simd
  import gf_inv_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW   = LANES * GF_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            simd_i,
  input  logic [MW-1:0]   width_i,
  input  logic [GF_W-1:0] poly_i,
  input  logic [DW-1:0]   data_i,
  output logic            valid_o,
  output logic [DW-1:0]   data_o
);
  gf_cfg_t         cfg;
  logic [DW-1:0]   res;

  gf_cfg_dec u_cfg (.width_i(width_i), .poly_i(poly_i), .cfg_o(cfg));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [GF_W-1:0] lane_in;
    if (k == 0) begin : g_first
      assign lane_in = data_i[GF_W-1:0];
    end else begin : g_rest
      // data gating for idle upper lanes
      assign lane_in = simd_i ? data_i[k*GF_W +: GF_W] : '0;
    end
    gf_inv_lane u_lane (.a_i(lane_in), .cfg_i(cfg), .inv_o(res[k*GF_W +: GF_W]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res;
    end
  end
endmodule

// File: rtl/gf_inv_simd_chk.sv
module gf_inv_simd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        simd_i,
  input logic [3:0]  width_i,
  input logic [31:0] data_i,
  input logic        valid_o,
  input logic [31:0] data_o
);
  a_r2_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  a_r6_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i[7:0] == 8'h00) |=> data_o[7:0] == 8'h00);
  a_r4_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && width_i == 4'd8 && data_i[7:0] != 8'h00) |=> data_o[7:0] != 8'h00);
  a_r10_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !simd_i) |=> data_o[31:8] == 24'h0);
endmodule

bind gf_inv_simd gf_inv_simd_chk i_chk (.*);

// File: tb/test_gf_inv_simd.sv
module test_gf_inv_simd;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        simd_i = 1'b0;
  logic [3:0]  width_i = 4'd8;
  logic [7:0]  poly_i = 8'h1B;
  logic [31:0] data_i = '0;
  logic        valid_o;
  logic [31:0] data_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic        exp_valid = 1'b0;
  logic [31:0] exp_data = '0;
  logic [31:0] last_in = '0;
  int          last_m = 8;
  int          last_p = 'h1B;

  always #2.5 clk_i = ~clk_i;

  gf_inv_simd i_gf_inv_simd (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .simd_i(simd_i),
    .width_i(width_i), .poly_i(poly_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  function automatic int ref_mul(int a, int b, int m, int p);
    int r = 0;
    for (int i = m - 1; i >= 0; i--) begin
      r = r << 1;
      if (((r >> m) & 1) == 1) r = r ^ ((1 << m) | p);
      if (((b >> i) & 1) == 1) r = r ^ a;
    end
    return r;
  endfunction

  function automatic int ref_inv(int a, int m, int p);
    if (a == 0) return 0;
    for (int b = 1; b < (1 << m); b++) if (ref_mul(a, b, m, p) == 1) return b;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one cycle, update model, compare after the edge
  task automatic step(input bit v, input bit simd, input int w, input int poly,
                      input logic [31:0] d, input string tag);
    int m, p, a;
    @(negedge clk_i);
    valid_i = v; simd_i = simd; width_i = 4'(w); poly_i = 8'(poly); data_i = d;
    m = (w >= 2 && w <= 8) ? w : 8;
    p = poly & ((1 << m) - 1);
    exp_valid = v;
    if (v) begin
      last_in = '0; last_m = m; last_p = p;
      for (int k = 0; k < 4; k++) begin
        a = (k == 0 || simd) ? int'(d[8*k +: 8]) & ((1 << m) - 1) : 0;
        last_in[8*k +: 8] = 8'(a);
        exp_data[8*k +: 8] = 8'(ref_inv(a, m, p));
      end
    end
    @(posedge clk_i);
    #1;
    chk(valid_o == exp_valid, "R2", 32'(valid_o), 32'(exp_valid));
    chk(data_o == exp_data, tag, data_o, exp_data);
  endtask

  // product of each registered lane with its input must be one
  task automatic prod_chk(input string tag);
    int a, b;
    for (int k = 0; k < 4; k++) begin
      a = int'(last_in[8*k +: 8]);
      b = int'(data_o[8*k +: 8]);
      if (a != 0) chk(ref_mul(a, b, last_m, last_p) == 1, tag, 32'(b), 32'(ref_inv(a, last_m, last_p)));
    end
  endtask

  task automatic sweep(input int m, input int poly);
    for (int base = 0; base < (1 << m); base += 4) begin
      step(1, 1, m, poly, {8'(base+3), 8'(base+2), 8'(base+1), 8'(base)}, (m == 8) ? "R4" : "R5");
      prod_chk((m == 8) ? "R4" : "R5");
    end
  endtask

  task automatic run_all;
    repeat (3) @(posedge clk_i);
    #1;
    chk(valid_o == 1'b0, "R1", 32'(valid_o), 32'h0);
    chk(data_o == '0, "R1", data_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R4 R5 R11: every element of each field through all lanes
    sweep(2, 'h3);
    sweep(3, 'h3);
    sweep(3, 'h5);
    sweep(4, 'h3);
    sweep(5, 'h5);
    sweep(6, 'h3);
    sweep(7, 'h3);
    sweep(8, 'h1B);
    sweep(8, 'h1D);

    // R6: zero in every lane
    for (int m = 2; m <= 8; m++) step(1, 1, m, 'h3, 32'h0, "R6");

    // R7: junk above bit m-1
    step(1, 1, 4, 'h3, 32'hF3A5_7C91, "R7");
    step(1, 1, 5, 'h5, 32'hE0FF_21C7, "R7");
    // R8: junk above poly bit m-1
    step(1, 1, 4, 'hF3, 32'h0907_0502, "R8");
    step(1, 1, 6, 'hC3, 32'h3F21_0A11, "R8");

    // R9: illegal widths act as 8
    step(1, 1, 0, 'h1B, 32'h53CA_0201, "R9");
    step(1, 1, 1, 'h1B, 32'hFF80_7F10, "R9");
    step(1, 1, 12, 'h1B, 32'h1234_5678, "R9");
    step(1, 1, 15, 'h1D, 32'h9ABC_DEF0, "R9");
    prod_chk("R9");

    // R10: scalar mode clears upper lanes
    step(1, 0, 8, 'h1B, 32'hA1B2_C3D4, "R10");
    step(1, 0, 3, 'h3, 32'h0706_0504, "R10");
    step(1, 1, 8, 'h1B, 32'hA1B2_C3D4, "R10");

    // R3: idle cycles with changing inputs
    step(0, 1, 8, 'h1B, 32'h1111_2222, "R3");
    step(0, 0, 4, 'h3, 32'hFFFF_FFFF, "R3");
    step(0, 1, 2, 'h1, 32'h0303_0303, "R3");
    step(1, 1, 8, 'h1B, 32'h0102_0304, "R2");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R2 act=hung exp=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule